// File: doc/BRIEF.md
# Relative-Address Butterfly Switch Fabric

This block moves up to eight packets per clock across a three-stage butterfly built from 2x2 switching elements. Each offered packet carries a source address, a destination address and a payload. On entry the fabric forms a routing tag by exclusive-OR of source and destination. Each stage looks at one bit of that tag. The bit tells the element whether the packet stays on its own line or swaps to the partner line. Every path through the fabric takes the same three hops. Even so, two packets can compete for one line inside a stage.

The fabric holds no buffers. A contest is settled in the same cycle: the packet that stays on its line keeps it, and the packet that tries to cross onto that line is refused. Each input port has a valid/ready pair. Ready is computed combinationally in the cycle the packet is offered. If valid is high and ready is high, the packet is taken and appears one clock later on the registered output line given by (input port) XOR (tag). If valid is high and ready is low, nothing is taken. The sender must keep the packet and offer it again. Ready may fall as a result of what the other ports offer in that cycle. The output side has a valid flag only. It cannot apply back-pressure, so a delivered packet is shown for exactly one cycle.

Top module: `bfly_net`

## Requirements
- R1: The routing tag of a packet offered on port p is src XOR dst (3 bits each). The packet leaves on output line p XOR tag. When src equals p, that line is dst.
- R2: Stage s (s = 0, 1, 2) pairs the lines whose indices differ only in bit s. It uses tag bit s: 0 keeps the packet on its line, 1 moves it to the partner line. For example, a packet from port 4 to address 6 (tag 010) swaps only in stage 1.
- R3: Outputs are registered. One clock after acceptance, out_valid of the exit line is 1, and that line carries the packet's source address and payload unchanged.
- R4: When a packet staying on a line and a packet crossing onto that line meet in a stage, the staying packet wins. The crossing packet is discarded, and its port's in_ready is 0 in the same cycle.
- R5: in_ready of a port with a valid packet is 1 exactly when that packet reaches an output. in_ready of an idle port is 1.
- R6: A packet offered alone is always accepted and delivered, for every source and destination pair.
- R7: If all offered packets share one tag value, none conflicts and all are accepted.
- R8: While reset is held, and one cycle after a cycle with no valid input, all out_valid bits are 0.
- R9: The number of out_valid bits set equals the number of packets accepted in the previous cycle. No packet is duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 8 | Per-port packet offered |
| in_ready | output | 8 | Per-port acceptance, combinational |
| in_src | input | 24 | Per-port source address, 3 bits per port |
| in_dst | input | 24 | Per-port destination address, 3 bits per port |
| in_data | input | 64 | Per-port payload, 8 bits per port |
| out_valid | output | 8 | Per-line packet delivered |
| out_src | output | 24 | Source address of the delivered packet, 3 bits per line |
| out_data | output | 64 | Payload of the delivered packet, 8 bits per line |

## Verification
The acceptance decision on in_ready belongs to the same cycle as the stimulus. Delivered packets appear on the outputs exactly one rising edge later. The bench applies each input pattern just after a falling edge. It reads in_ready one time unit later, while the pattern is still stable. It then reads the outputs at the following falling edge, after the single register stage has captured the pattern and before the next pattern is applied. An arithmetic model computes the expected grants and exit lines, stage by stage, from the tag bits and the stay-wins rule. It is checked over every single-packet route, every uniform-tag permutation, directed conflicts and a pseudo-random series.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  typedef enum logic [1:0] {
    RT_IDLE     = 2'd0,
    RT_STRAIGHT = 2'd1,
    RT_CROSS    = 2'd2
  } route_e;

  function automatic route_e pick_route(input logic vld, input logic tag_bit);
    if (!vld)        return RT_IDLE;
    else if (tag_bit) return RT_CROSS;
    else             return RT_STRAIGHT;
  endfunction

endpackage

// File: rtl/bfly_switch.sv
module bfly_switch
  import bfly_pkg::*;
#(
  parameter int PKT_W     = 18,
  parameter int VALID_POS = 17,
  parameter int TAG_BIT   = 14
) (
  input  logic [PKT_W-1:0] lo_in,
  input  logic [PKT_W-1:0] hi_in,
  output logic [PKT_W-1:0] lo_out,
  output logic [PKT_W-1:0] hi_out
);

  route_e lo_rt, hi_rt;

  always_comb begin
    lo_rt = pick_route(lo_in[VALID_POS], lo_in[TAG_BIT]);
    hi_rt = pick_route(hi_in[VALID_POS], hi_in[TAG_BIT]);

    // a packet holding its own line has priority over one crossing onto it
    if (lo_rt == RT_STRAIGHT)   lo_out = lo_in;
    else if (hi_rt == RT_CROSS) lo_out = hi_in;
    else                        lo_out = '0;

    if (hi_rt == RT_STRAIGHT)   hi_out = hi_in;
    else if (lo_rt == RT_CROSS) hi_out = lo_in;
    else                        hi_out = '0;
  end

endmodule

// File: rtl/bfly_stage.sv
module bfly_stage #(
  parameter int N         = 8,
  parameter int PKT_W     = 18,
  parameter int VALID_POS = 17,
  parameter int TAG_LSB   = 14,
  parameter int STAGE     = 0
) (
  input  logic [N-1:0][PKT_W-1:0] lanes_in,
  output logic [N-1:0][PKT_W-1:0] lanes_out
);

  localparam int HALF = N / 2;
  localparam int LOW_MASK = (1 << STAGE) - 1;

  for (genvar k = 0; k < HALF; k++) begin : g_elem
    // insert a zero at bit STAGE of k to find the lower line of the pair
    localparam int LO = ((k >> STAGE) << (STAGE + 1)) | (k & LOW_MASK);
    localparam int HI = LO | (1 << STAGE);

    bfly_switch #(
      .PKT_W    (PKT_W),
      .VALID_POS(VALID_POS),
      .TAG_BIT  (TAG_LSB + STAGE)
    ) u_sw (
      .lo_in (lanes_in[LO]),
      .hi_in (lanes_in[HI]),
      .lo_out(lanes_out[LO]),
      .hi_out(lanes_out[HI])
    );
  end

endmodule

// File: rtl/bfly_net.sv
module bfly_net #(
  parameter int LOG_N  = 3,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [(1<<LOG_N)-1:0]       in_valid,
  output logic [(1<<LOG_N)-1:0]       in_ready,
  input  logic [(1<<LOG_N)*LOG_N-1:0] in_src,
  input  logic [(1<<LOG_N)*LOG_N-1:0] in_dst,
  input  logic [(1<<LOG_N)*DATA_W-1:0] in_data,
  output logic [(1<<LOG_N)-1:0]       out_valid,
  output logic [(1<<LOG_N)*LOG_N-1:0] out_src,
  output logic [(1<<LOG_N)*DATA_W-1:0] out_data
);

  localparam int N         = 1 << LOG_N;
  localparam int A         = LOG_N;
  localparam int SRC_LSB   = DATA_W;
  localparam int ORG_LSB   = DATA_W + A;
  localparam int TAG_LSB   = DATA_W + 2 * A;
  localparam int VALID_POS = DATA_W + 3 * A;
  localparam int PKT_W     = VALID_POS + 1;

  logic [N-1:0][PKT_W-1:0] lane [LOG_N+1];

  // injection: build tag and remember the entry port
  for (genvar j = 0; j < N; j++) begin : g_inject
    assign lane[0][j] = {in_valid[j],
                         in_src[j*A +: A] ^ in_dst[j*A +: A],
                         A'(j),
                         in_src[j*A +: A],
                         in_data[j*DATA_W +: DATA_W]};
  end

  for (genvar s = 0; s < LOG_N; s++) begin : g_stage
    bfly_stage #(
      .N        (N),
      .PKT_W    (PKT_W),
      .VALID_POS(VALID_POS),
      .TAG_LSB  (TAG_LSB),
      .STAGE    (s)
    ) u_stage (
      .lanes_in (lane[s]),
      .lanes_out(lane[s+1])
    );
  end

  // a port is granted when its packet survives to some exit line
  logic [N-1:0] delivered;
  always_comb begin
    delivered = '0;
    for (int k = 0; k < N; k++) begin
      for (int j = 0; j < N; j++) begin
        if (lane[LOG_N][j][VALID_POS] && (lane[LOG_N][j][ORG_LSB +: A] == A'(k)))
          delivered[k] = 1'b1;
      end
    end
    in_ready = ~in_valid | delivered;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_src   <= '0;
      out_data  <= '0;
    end else begin
      for (int j = 0; j < N; j++) begin
        out_valid[j]                <= lane[LOG_N][j][VALID_POS];
        out_src[j*A +: A]           <= lane[LOG_N][j][SRC_LSB +: A];
        out_data[j*DATA_W +: DATA_W] <= lane[LOG_N][j][DATA_W-1:0];
      end
    end
  end

endmodule

// File: rtl/bfly_net_chk.sv
module bfly_net_chk #(
  parameter int LOG_N  = 3,
  parameter int DATA_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [(1<<LOG_N)-1:0]       in_valid,
  input logic [(1<<LOG_N)-1:0]       in_ready,
  input logic [(1<<LOG_N)*LOG_N-1:0] in_src,
  input logic [(1<<LOG_N)*LOG_N-1:0] in_dst,
  input logic [(1<<LOG_N)-1:0]       out_valid
);

  localparam int N = 1 << LOG_N;
  localparam int A = LOG_N;

  logic [A-1:0] tg [N];
  for (genvar k = 0; k < N; k++) begin : g_tag
    assign tg[k] = in_src[k*A +: A] ^ in_dst[k*A +: A];
  end

  logic uniform;
  always_comb begin
    uniform = 1'b1;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (in_valid[i] && in_valid[j] && (tg[i] != tg[j])) uniform = 1'b0;
  end

  // R9
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(out_valid) == $past($countones(in_valid & in_ready))));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == '0) |=> (out_valid == '0));

  // R6
  lone_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(in_valid) == 1) |-> ((in_valid & ~in_ready) == '0));

  // R7
  uniform_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uniform |-> ((in_valid & ~in_ready) == '0));

  for (genvar k = 0; k < N; k += 2) begin : g_pair
    // R4
    stay_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[k] && in_valid[k+1] && !tg[k][0] && tg[k+1][0]) |-> !in_ready[k+1]);
  end

endmodule

bind bfly_net bfly_net_chk #(.LOG_N(LOG_N), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_src   (in_src),
  .in_dst   (in_dst),
  .out_valid(out_valid)
);

// File: tb/bfly_net_test.sv
module bfly_net_test;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_N = 3;
  localparam int N = 8;
  localparam int A = 3;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   in_valid = '0;
  logic [N-1:0]   in_ready;
  logic [N*A-1:0] in_src = '0;
  logic [N*A-1:0] in_dst = '0;
  logic [N*W-1:0] in_data = '0;
  logic [N-1:0]   out_valid;
  logic [N*A-1:0] out_src;
  logic [N*W-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfly_net #(.LOG_N(LOG_N), .DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_dst(in_dst), .in_data(in_data),
    .out_valid(out_valid), .out_src(out_src), .out_data(out_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic         sv   [N];
  logic [A-1:0] ss   [N];
  logic [A-1:0] sd   [N];
  logic [W-1:0] sdat [N];
  logic         egr  [N];
  logic         ev   [N];
  logic [A-1:0] esrc [N];
  logic [W-1:0] edat [N];
  logic [15:0]  lf = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_stim();
    for (int k = 0; k < N; k++) begin
      sv[k] = 1'b0; ss[k] = '0; sd[k] = '0; sdat[k] = '0;
    end
  endtask

  // stage-by-stage model: stay wins, crossing onto an occupied line is dropped
  task automatic model();
    int  line [N];
    bit  alive [N];
    bit  kill [N];
    logic [A-1:0] tg [N];
    for (int k = 0; k < N; k++) begin
      line[k] = k; alive[k] = sv[k]; tg[k] = ss[k] ^ sd[k];
      ev[k] = 1'b0; esrc[k] = '0; edat[k] = '0;
    end
    for (int s = 0; s < LOG_N; s++) begin
      for (int k = 0; k < N; k++) begin
        kill[k] = 1'b0;
        if (alive[k] && tg[k][s]) begin
          for (int m = 0; m < N; m++)
            if (m != k && alive[m] && !tg[m][s] && line[m] == (line[k] ^ (1 << s)))
              kill[k] = 1'b1;
        end
      end
      for (int k = 0; k < N; k++) begin
        if (kill[k]) alive[k] = 1'b0;
        if (alive[k] && tg[k][s]) line[k] = line[k] ^ (1 << s);
      end
    end
    for (int k = 0; k < N; k++) begin
      egr[k] = !sv[k] || alive[k];
      if (alive[k]) begin
        ev[line[k]] = 1'b1; esrc[line[k]] = ss[k]; edat[line[k]] = sdat[k];
      end
    end
  endtask

  task automatic run_case(input string req);
    int granted;
    model();
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      in_valid[k] = sv[k];
      in_src[k*A +: A] = ss[k];
      in_dst[k*A +: A] = sd[k];
      in_data[k*W +: W] = sdat[k];
    end
    #1;
    granted = 0;
    for (int k = 0; k < N; k++) begin
      chk(in_ready[k] == egr[k], "R5", $sformatf("ready[%0d]", k), in_ready[k], egr[k]);
      if (in_valid[k] && in_ready[k]) granted++;
    end
    @(negedge clk);
    chk($countones(out_valid) == granted, "R9", "delivered count", $countones(out_valid), granted);
    for (int j = 0; j < N; j++) begin
      chk(out_valid[j] == ev[j], req, $sformatf("out_valid[%0d]", j), out_valid[j], ev[j]);
      if (ev[j]) begin
        chk(out_src[j*A +: A] == esrc[j], "R3", $sformatf("out_src[%0d]", j), out_src[j*A +: A], esrc[j]);
        chk(out_data[j*W +: W] == edat[j], "R3", $sformatf("out_data[%0d]", j), out_data[j*W +: W], edat[j]);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    clear_stim();
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R8", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0, "R8", "out_valid after reset", out_valid, 0);

    // R6: every lone route, src equal to port
    for (int p = 0; p < N; p++) begin
      for (int d = 0; d < N; d++) begin
        clear_stim();
        sv[p] = 1'b1; ss[p] = A'(p); sd[p] = A'(d); sdat[p] = W'(p * 16 + d);
        run_case("R6");
        chk(out_valid[d] == 1'b1, "R1", "lone packet at dst line", out_valid[d], 1);
      end
    end

    // R2: port 4 to address 6 crosses only in stage 1
    clear_stim();
    sv[4] = 1'b1; ss[4] = 3'd4; sd[4] = 3'd6; sdat[4] = 8'h5A;
    run_case("R2");
    chk(out_valid == 8'b0100_0000, "R2", "exit line pattern", out_valid, 8'b0100_0000);

    // R1: src differs from port, tag 0 keeps the line
    clear_stim();
    sv[2] = 1'b1; ss[2] = 3'd5; sd[2] = 3'd5; sdat[2] = 8'hC3;
    run_case("R1");
    chk(out_valid == 8'b0000_0100, "R1", "exit line with src!=port", out_valid, 8'b0000_0100);
    chk(out_src[2*A +: A] == 3'd5, "R1", "carried src", out_src[2*A +: A], 5);

    // R4: port 4 stays in stage 0, port 5 crosses onto line 4
    clear_stim();
    sv[4] = 1'b1; ss[4] = 3'd4; sd[4] = 3'd6; sdat[4] = 8'h11;
    sv[5] = 1'b1; ss[5] = 3'd5; sd[5] = 3'd4; sdat[5] = 8'h22;
    @(negedge clk);
    run_case("R4");
    chk(egr[5] == 1'b0 && egr[4] == 1'b1, "R4", "model stay-wins", egr[5], 0);

    // R7: full permutations with one common tag
    for (int t = 0; t < N; t++) begin
      clear_stim();
      for (int k = 0; k < N; k++) begin
        sv[k] = 1'b1; ss[k] = A'(k); sd[k] = A'(k ^ t); sdat[k] = W'(t * 8 + k);
      end
      run_case("R7");
      for (int k = 0; k < N; k++)
        chk(in_ready[k] == 1'b1, "R7", $sformatf("uniform ready[%0d]", k), in_ready[k], 1);
    end

    // pseudo-random mixes
    for (int r = 0; r < 60; r++) begin
      clear_stim();
      for (int k = 0; k < N; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        sv[k] = lf[0] | lf[5];
        ss[k] = lf[7] ? lf[3:1] : A'(k);
        sd[k] = lf[11:9];
        sdat[k] = lf[15:8] ^ W'(r);
      end
      run_case("R4");
    end

    // R8: idle cycle empties the outputs
    clear_stim();
    run_case("R8");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule